// File: doc/BRIEF.md
# Run-Time Reloadable Bit-Serial FIR Filter

This block is a finite impulse response filter built without multipliers. The taps are split into fixed groups, and each group owns a small table. Entry `a` of a group's table holds the sum of the coefficients whose tap bit is set in `a`. To produce one output, the filter reads these tables with columns of bits taken from the stored input history, then scales each table result by its bit weight and adds it into a running total. The tables are writable memories, so an outside agent can load a new coefficient set by writing precomputed group sums. The filter structure itself does not change.

The input word is split into `SECT_Q` equal bit fields, and each field is handled by its own section. A section steps through the `DATA_W/SECT_Q` bit positions of its field, one position per clock, and keeps its own total. Two adjacent sections share one two-read-port table per tap group. A registered adder tree then weights each section total by the position of its field and combines them into the final output. The block accepts a new sample every `DATA_W/SECT_Q` cycles and signals each finished result with a one-cycle valid pulse.

Top module: `dafir_core`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `out_data` is 0 and the sample history is all zero. The first output after reset therefore depends only on the newest sample.
- R2: Each output equals the exact two's-complement sum over k = 0..TAPS-1 of h[k]·x[n-k]. Here x[n] is the newest accepted sample, and `out_data` is OUT_W = COEF_W + DATA_W + log2(TAPS) bits wide.
- R3: A write with `tbl_we` high stores `tbl_data` at entry `tbl_addr` of group table `tbl_group`. Bit k of the entry address stands for tap `tbl_group*GROUP + k`, and the stored value must be the signed sum of the coefficients of the taps whose bits are set. Samples accepted after the write use the new contents, so reloading all entries changes the coefficient set.
- R4: A table write that arrives while a sample is being processed is ignored, and later outputs still use the previous contents.
- R5: A sample is accepted when `in_valid` is high and the block is idle or in the last bit-position cycle of the current sample. A sample offered in any other processing cycle is ignored and does not enter the history.
- R6: With `in_valid` held high, a new sample is accepted every DATA_W/SECT_Q cycles, and every accepted sample produces its own correct output.
- R7: `out_valid` pulses for exactly one cycle, DATA_W/SECT_Q + log2(SECT_Q) + 1 cycles after the clock edge that accepted the sample.
- R8: The top bit position of the top section carries negative weight. Full-scale negative samples and coefficients (-128 with the 8-bit defaults) give the correct signed result.
- R9: `out_data` holds its value between `out_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A sample is offered on `in_sample` |
| in_sample | input | DATA_W | Two's-complement input sample |
| tbl_we | input | 1 | Table write request |
| tbl_group | input | GSEL_W | Selects which tap-group table is written |
| tbl_addr | input | GROUP | Table entry; bit k selects tap group*GROUP+k |
| tbl_data | input | TBL_W | Signed group sum written to the entry |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | OUT_W | Two's-complement filter output, held between pulses |

## Verification
The hardest case to reach from the ports is input that arrives while a sample is still being processed, because the block must tell the last bit-position cycle apart from the ones before it. The bench creates this in three ways. First, it holds `in_valid` high with garbage data through the early processing cycles and drops it just before the acceptance edge. Second, it streams samples back to back so that every acceptance lands on a last-position cycle. Third, it issues table writes in the middle of processing, using all-ones samples so that every bit position reads the very entry those writes target.

// File: rtl/dafir_pkg.sv
// Package dafir_pkg
// Shared types and width helpers for the bit-serial table-lookup FIR.
// Assumes nothing beyond the IEEE 1800-2017 language.
package dafir_pkg;

    // Sequencer state: waiting for a sample, or stepping through bit positions
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Width of a selector over n items; never narrower than one bit
    function automatic int sel_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dafir_lut_ram.sv
// Module dafir_lut_ram
// Writable group-sum table with one write port and two asynchronous read
// ports, so that two sections can share one copy of the storage.
// Assumes the contents are loaded before they are used; the storage is not reset.
module dafir_lut_ram #(
    parameter int AW = 4,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store one entry per accepted write
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Both read ports see the stored contents without delay
    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];

endmodule

// File: rtl/dafir_section.sv
// Module dafir_section
// One bit-field section. In each run cycle it builds the table addresses from
// bit position (SEC_IDX*SLICE_R + slc) of every stored sample, sums the group
// table outputs, and adds that sum, scaled by 2^slc, into its total. When
// LAST_SEC is set, the final position is subtracted (two's-complement sign weight).
// Assumes slc counts 0..SLICE_R-1 while run is high and restarts at 0 per sample.
module dafir_section #(
    parameter int DATA_W  = 8,
    parameter int TAPS    = 8,
    parameter int GROUPS  = 2,
    parameter int SLICE_R = 4,
    parameter int SW      = 2,
    parameter int TBL_W   = 10,
    parameter int OUT_W   = 19,
    parameter int SEC_IDX = 0,
    parameter bit LAST_SEC = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic [SW-1:0]            slc,
    input  logic [TAPS*DATA_W-1:0]   tap_bus,
    input  logic [GROUPS*TBL_W-1:0]  lut_rd,
    output logic [TAPS-1:0]          lut_addr,
    output logic signed [OUT_W-1:0]  acc
);
    localparam int BASE_BIT = SEC_IDX * SLICE_R;

    logic signed [OUT_W-1:0] slice_sum;
    logic signed [OUT_W-1:0] weighted;
    logic                    neg_step;
    logic                    first_step;

    // Gather the current bit position of every tap; tap t drives address bit t
    always_comb begin
        lut_addr = '0;
        for (int t = 0; t < TAPS; t++) begin
            lut_addr[t] = tap_bus[t*DATA_W + BASE_BIT + int'(slc)];
        end
    end

    // Sign-extend and add the group table outputs
    always_comb begin
        slice_sum = '0;
        for (int g = 0; g < GROUPS; g++) begin
            slice_sum = slice_sum +
                {{(OUT_W-TBL_W){lut_rd[g*TBL_W+TBL_W-1]}}, lut_rd[g*TBL_W +: TBL_W]};
        end
    end

    assign weighted   = slice_sum <<< slc;
    assign first_step = (slc == '0);
    assign neg_step   = LAST_SEC && (slc == SW'(SLICE_R-1));

    // Scale and add (or subtract, on the sign position) into the section total
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (run) begin
            acc <= (first_step ? '0 : acc) + (neg_step ? -weighted : weighted);
        end
    end

    // R5: the total moves only while a sample is being processed
    p_acc_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(acc));

endmodule

// File: rtl/dafir_add_tree.sv
// Module dafir_add_tree
// Registered binary adder tree over N signed inputs, with one register level
// per tree level, plus a valid pipeline of matching depth.
// Assumes N >= 2; missing leaves up to the next power of two read as zero.
module dafir_add_tree #(
    parameter int N = 2,
    parameter int W = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vin,
    input  logic [N*W-1:0]       din,
    output logic                 vout,
    output logic signed [W-1:0]  dout
);
    localparam int LEVELS = $clog2(N);
    localparam int PADN   = 1 << LEVELS;

    logic signed [W-1:0] leaf [PADN];
    logic signed [W-1:0] node [1:PADN-1];
    logic [LEVELS-1:0]   vpipe;

    for (genvar i = 0; i < PADN; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign leaf[i] = din[i*W +: W];
        end else begin : g_pad
            assign leaf[i] = '0;
        end
    end

    // Child of heap node: a leaf below the last level, else an inner node
    function automatic logic signed [W-1:0] kid(input int j);
        return (j >= PADN) ? leaf[j-PADN] : node[j];
    endfunction

    // Every inner node registers the sum of its two children
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i < PADN; i++) node[i] <= '0;
        end else begin
            for (int i = 1; i < PADN; i++) node[i] <= kid(2*i) + kid(2*i+1);
        end
    end

    // Delay the valid flag by one cycle per tree level
    always_ff @(posedge clk) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= (vpipe << 1) | LEVELS'(vin);
    end

    assign vout = vpipe[LEVELS-1];
    assign dout = node[1];

    // R7: a result leaves the tree exactly LEVELS cycles after it enters
    p_tree_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vout |-> $past(vin, LEVELS));

endmodule

// File: rtl/dafir_core.sv
// Module dafir_core
// Table-lookup FIR with run-time writable group tables. It keeps a sample
// history, steps every section through its bit positions in parallel, merges
// the section totals in a registered tree, and registers the result.
// Assumes DATA_W is a multiple of SECT_Q, TAPS a multiple of GROUP,
// SECT_Q >= 2 and DATA_W/SECT_Q >= 2.
module dafir_core
    import dafir_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int TAPS   = 8,
    parameter int GROUP  = 4,
    parameter int SECT_Q = 2,
    localparam int GROUPS  = TAPS / GROUP,
    localparam int GSEL_W  = sel_w(GROUPS),
    localparam int TBL_W   = COEF_W + $clog2(GROUP),
    localparam int OUT_W   = COEF_W + DATA_W + $clog2(TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              tbl_we,
    input  logic [GSEL_W-1:0] tbl_group,
    input  logic [GROUP-1:0]  tbl_addr,
    input  logic [TBL_W-1:0]  tbl_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data
);
    localparam int SLICE_R = DATA_W / SECT_Q;
    localparam int SW      = sel_w(SLICE_R);
    localparam int PAIRS   = (SECT_Q + 1) / 2;

    run_state_e              state;
    logic [SW-1:0]           slc;
    logic                    busy;
    logic                    last_slc;
    logic                    accept;
    logic                    done_r;
    logic                    tbl_wr_ok;
    logic [DATA_W-1:0]       taps [TAPS];
    logic [TAPS*DATA_W-1:0]  tap_bus;
    logic [TAPS-1:0]         sec_addr [SECT_Q];
    logic [TBL_W-1:0]        rd_sg [SECT_Q][GROUPS];
    logic signed [OUT_W-1:0] sec_acc [SECT_Q];
    logic [SECT_Q*OUT_W-1:0] tree_in;
    logic                    tree_v;
    logic signed [OUT_W-1:0] tree_d;
    logic [SW:0]             gap_cnt;

    assign busy      = (state == ST_RUN);
    assign last_slc  = busy && (slc == SW'(SLICE_R-1));
    assign accept    = in_valid && (!busy || last_slc);
    assign tbl_wr_ok = tbl_we && !busy;

    // Shift the accepted sample into the history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) taps[k] <= '0;
        end else if (accept) begin
            taps[0] <= in_sample;
            for (int k = 1; k < TAPS; k++) taps[k] <= taps[k-1];
        end
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_bus
        assign tap_bus[k*DATA_W +: DATA_W] = taps[k];
    end

    // Sequence bit positions: start on accept, stop after the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            slc   <= '0;
        end else if (accept) begin
            state <= ST_RUN;
            slc   <= '0;
        end else if (last_slc) begin
            state <= ST_IDLE;
        end else if (busy) begin
            slc <= slc + 1'b1;
        end
    end

    // Flag the cycle in which all section totals are final
    always_ff @(posedge clk) begin
        if (!rst_n) done_r <= 1'b0;
        else        done_r <= last_slc;
    end

    // Tables: one shared copy per section pair and tap group
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            logic we_g;
            assign we_g = tbl_wr_ok && (tbl_group == GSEL_W'(g));
            if (2*p+1 < SECT_Q) begin : g_dual
                dafir_lut_ram #(.AW(GROUP), .DW(TBL_W)) u_ram (
                    .clk     (clk),
                    .we      (we_g),
                    .waddr   (tbl_addr),
                    .wdata   (tbl_data),
                    .ra_addr (sec_addr[2*p][g*GROUP +: GROUP]),
                    .ra_data (rd_sg[2*p][g]),
                    .rb_addr (sec_addr[2*p+1][g*GROUP +: GROUP]),
                    .rb_data (rd_sg[2*p+1][g])
                );
            end else begin : g_single
                logic [TBL_W-1:0] spare_rd;
                dafir_lut_ram #(.AW(GROUP), .DW(TBL_W)) u_ram (
                    .clk     (clk),
                    .we      (we_g),
                    .waddr   (tbl_addr),
                    .wdata   (tbl_data),
                    .ra_addr (sec_addr[2*p][g*GROUP +: GROUP]),
                    .ra_data (rd_sg[2*p][g]),
                    .rb_addr ('0),
                    .rb_data (spare_rd)
                );
            end
        end
    end

    // Sections, each feeding a field-weighted total into the tree
    for (genvar q = 0; q < SECT_Q; q++) begin : g_sec
        logic [GROUPS*TBL_W-1:0] rd_flat;
        for (genvar g = 0; g < GROUPS; g++) begin : g_pack
            assign rd_flat[g*TBL_W +: TBL_W] = rd_sg[q][g];
        end
        dafir_section #(
            .DATA_W (DATA_W), .TAPS (TAPS), .GROUPS (GROUPS),
            .SLICE_R (SLICE_R), .SW (SW), .TBL_W (TBL_W), .OUT_W (OUT_W),
            .SEC_IDX (q), .LAST_SEC (q == SECT_Q-1)
        ) u_sec (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (busy),
            .slc      (slc),
            .tap_bus  (tap_bus),
            .lut_rd   (rd_flat),
            .lut_addr (sec_addr[q]),
            .acc      (sec_acc[q])
        );
        assign tree_in[q*OUT_W +: OUT_W] = sec_acc[q] <<< (q*SLICE_R);
    end

    dafir_add_tree #(.N(SECT_Q), .W(OUT_W)) u_tree (
        .clk   (clk),
        .rst_n (rst_n),
        .vin   (done_r),
        .din   (tree_in),
        .vout  (tree_v),
        .dout  (tree_d)
    );

    // Capture each finished result and hold it until the next one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= tree_v;
            if (tree_v) out_data <= tree_d;
        end
    end

    // Cycles since the last accept, saturating; used only by an assertion
    always_ff @(posedge clk) begin
        if (!rst_n)                           gap_cnt <= (SW+1)'(SLICE_R);
        else if (accept)                      gap_cnt <= '0;
        else if (gap_cnt < (SW+1)'(SLICE_R))  gap_cnt <= gap_cnt + 1'b1;
    end

    // R6: accepts are never closer than one full bit-position sweep
    p_accept_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (gap_cnt >= (SW+1)'(SLICE_R-1)));

    // R5: without a new sample the sequencer goes idle after the last position
    p_sweep_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_slc && !in_valid) |=> !busy);

    // R7: the result flag is a single-cycle pulse
    p_out_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R9: the output value moves only together with the valid pulse
    p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

endmodule

// File: tb/dafir_core_bench.sv
// Bench dafir_core_bench
// Directed scenarios for dafir_core. The bench loads the group tables from
// coefficient sets, keeps its own sample history and a direct convolution
// model, and compares every output pulse against a queue of expected values.
module dafir_core_bench;
    localparam int  CLK_PERIOD = 10;
    localparam int  DATA_W = 8;
    localparam int  COEF_W = 8;
    localparam int  TAPS   = 8;
    localparam int  GROUP  = 4;
    localparam int  SECT_Q = 2;
    localparam int  GROUPS = TAPS / GROUP;
    localparam int  TBL_W  = COEF_W + $clog2(GROUP);
    localparam int  OUT_W  = COEF_W + DATA_W + $clog2(TAPS);
    localparam int  SLICE_R = DATA_W / SECT_Q;
    localparam int  LAT    = SLICE_R + $clog2(SECT_Q) + 1;
    localparam int  WD_LIMIT = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_sample = '0;
    logic              tbl_we = 1'b0;
    logic [0:0]        tbl_group = '0;
    logic [GROUP-1:0]  tbl_addr = '0;
    logic [TBL_W-1:0]  tbl_data = '0;
    logic              out_valid;
    logic [OUT_W-1:0]  out_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int coef [TAPS];
    int hist [TAPS];
    int exp_q [0:1023];
    int wr_idx = 0;
    int rd_idx = 0;
    string cur_req = "R2";

    dafir_core u_dafir_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .tbl_we    (tbl_we),
        .tbl_group (tbl_group),
        .tbl_addr  (tbl_addr),
        .tbl_data  (tbl_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int got, input int expv);
        checks++;
        if (got != expv) begin
            failures++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            failures++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Compare every output pulse against the next expected value (R2)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd_idx == wr_idx) begin
                check("R5", "unexpected output pulse", 1, 0);
            end else begin
                check(cur_req, "output value", int'($signed(out_data)), exp_q[rd_idx]);
                rd_idx++;
            end
        end
    end

    // Reference model: record an accepted sample and queue the convolution
    task automatic push(input int x);
        int acc = 0;
        for (int k = TAPS-1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        for (int k = 0; k < TAPS; k++) acc += coef[k] * hist[k];
        exp_q[wr_idx] = acc;
        wr_idx++;
    endtask

    // Write every group table from the current coefficient set (R3 encoding)
    task automatic load_tables();
        for (int g = 0; g < GROUPS; g++) begin
            for (int a = 0; a < (1 << GROUP); a++) begin
                int s = 0;
                for (int k = 0; k < GROUP; k++) if (a[k]) s += coef[g*GROUP + k];
                @(negedge clk);
                tbl_we = 1'b1;
                tbl_group = 1'(g);
                tbl_addr = GROUP'(a);
                tbl_data = TBL_W'(s);
            end
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic wait_drain(input string req);
        int t = 0;
        while (rd_idx != wr_idx && t < 200) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        check(req, "all expected outputs seen", rd_idx, wr_idx);
    endtask

    // One isolated sample: value, latency (R7) and hold (R9)
    task automatic send_one(input int x, input string req);
        int cnt = 0;
        int expv;
        cur_req = req;
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = DATA_W'(x);
        push(x);
        expv = exp_q[wr_idx-1];
        @(negedge clk);
        in_valid = 1'b0;
        while (!out_valid && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        check("R7", "cycles from accept to pulse", cnt, LAT);
        @(negedge clk);
        check("R7", "pulse length one cycle", int'(out_valid), 0);
        check("R9", "output held after pulse", int'($signed(out_data)), expv);
        repeat (2) @(negedge clk);
        check("R9", "output still held", int'($signed(out_data)), expv);
    endtask

    task automatic test_reset_r1();
        cur_req = "R1";
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < TAPS; k++) hist[k] = 0;
        @(negedge clk);
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "out_data after reset", int'($signed(out_data)), 0);
        coef = '{3, -5, 7, -11, 13, -17, 19, -23};
        load_tables();
        send_one(1, "R1");
        wait_drain("R1");
    endtask

    task automatic test_patterns_r2();
        send_one(5, "R2");
        send_one(-7, "R2");
        send_one(127, "R2");
        send_one(0, "R2");
        send_one(-1, "R8");
        send_one(-128, "R8");
        send_one(85, "R2");
        send_one(-86, "R2");
        wait_drain("R2");
    endtask

    // Back-to-back samples with in_valid held high
    task automatic test_stream_r6(input int n, input int seed);
        cur_req = "R6";
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            int x = ((i*37 + seed) % 256) - 128;
            in_valid = 1'b1;
            in_sample = DATA_W'(x);
            push(x);
            repeat (SLICE_R) @(negedge clk);
        end
        in_valid = 1'b0;
        wait_drain("R6");
    endtask

    // Garbage offered during processing must not enter the history
    task automatic test_ignore_r5();
        cur_req = "R5";
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = DATA_W'(42);
        push(42);
        @(negedge clk);
        in_sample = DATA_W'(-99);
        repeat (SLICE_R-1) @(negedge clk);
        in_valid = 1'b0;
        wait_drain("R5");
        send_one(9, "R5");
        send_one(-3, "R5");
        wait_drain("R5");
    endtask

    // Table writes during processing must be dropped
    task automatic test_write_block_r4();
        cur_req = "R4";
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = DATA_W'(-1);
        push(-1);
        @(negedge clk);
        in_valid = 1'b0;
        tbl_we = 1'b1;
        tbl_group = 1'b0;
        tbl_addr = '1;
        tbl_data = TBL_W'(341);
        @(negedge clk);
        tbl_group = 1'b1;
        @(negedge clk);
        tbl_addr = GROUP'(14);
        @(negedge clk);
        tbl_we = 1'b0;
        wait_drain("R4");
        send_one(-1, "R4");
        send_one(-1, "R4");
        send_one(77, "R4");
        wait_drain("R4");
    endtask

    // Reload a new coefficient set, then the full-scale negative corner
    task automatic test_reload_r3();
        coef = '{127, -128, 64, -1, 0, 1, -64, 100};
        load_tables();
        send_one(3, "R3");
        send_one(-128, "R3");
        send_one(127, "R3");
        test_stream_r6(12, 11);
        coef = '{-128, -128, -128, -128, -128, -128, -128, -128};
        load_tables();
        cur_req = "R8";
        for (int i = 0; i < TAPS; i++) send_one(-128, "R8");
        send_one(127, "R8");
        wait_drain("R8");
    endtask

    initial begin
        for (int k = 0; k < TAPS; k++) begin
            hist[k] = 0;
            coef[k] = 0;
        end
        test_reset_r1();
        test_patterns_r2();
        test_stream_r6(24, 5);
        test_ignore_r5();
        test_write_block_r4();
        test_reload_r3();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule